// File: doc/BRIEF.md
# Split-Access 64-bit Register Bridge

This block lets a host bus that moves only 32 bits per access reach a bank of 64-bit control registers. Each register occupies a slot on a 0x40-byte stride, and address bit 2 chooses between the two halves of an access. One 32-bit holding latch serves both directions. A low-half write parks its data in the latch. The matching high-half write then commits the whole 64-bit word in one strobe. A low-half read returns the lower word at once and parks the upper word in the latch, where the following high-half read picks it up.

On the far side, the bridge drives a plain 64-bit register port: slot index, write strobe, write data, read strobe, decode hit and read data. The register storage sits behind that port. Host read data is registered and appears one cycle after the request. An error pulse, aligned with that response slot, marks an access to an offset that is not mapped. The host never issues a read and a write in the same cycle.

Top module: `hbsb_bridge`

## Requirements
- R1: After reset the latch holds zero, and `hst_rvalid`, `hst_err`, `rf_wr` and `rf_rd` are low; a high-half read issued straight after reset returns 0.
- R2: A write with address bit 2 clear loads `hst_wdata` into the latch, whatever the offset. It raises no `rf_wr`, no `hst_rvalid` and no `hst_err`.
- R3: A write with address bit 2 set to a mapped slot raises `rf_wr` in the request cycle. In that cycle `rf_idx` is the slot number and `rf_wdata` is {`hst_wdata` in bits 63:32, latch in bits 31:0}.
- R4: A read with address bit 2 clear to a mapped slot raises `rf_rd` in the request cycle. One cycle later it returns `rf_rdata[31:0]` with `hst_rvalid` high, and it loads `rf_rdata[63:32]` into the latch.
- R5: A read with address bit 2 set returns the latch one cycle later with `hst_rvalid` high and `hst_err` low. This holds even at an unmapped offset, and the latch is left unchanged.
- R6: A read with address bit 2 clear to an unmapped offset returns 32'hFFFF_FFFF with `hst_rvalid` and `hst_err` both high. It leaves the latch unchanged.
- R7: A write with address bit 2 set to an unmapped offset raises `hst_err` one cycle later. It does not raise `rf_wr`, so no register changes.
- R8: An offset is mapped when address bits 5:3 are zero and the slot number `hst_addr[AW-1:6]` is below `NUM_REGS`. Address bits 1:0 are ignored.
- R9: `hst_rvalid` and `hst_err` are high only in the cycle after a request. `hst_err` is high only for the unmapped cases of R6 and R7.
- R10: The latch is shared. A low-half read placed between the two halves of a write replaces the parked low word, so the commit carries the upper half of the register that was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_req | input | 1 | Host access request, one cycle per access |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_addr | input | AW | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Registered host read data |
| hst_rvalid | output | 1 | Read data valid, one cycle after a read request |
| hst_err | output | 1 | Unassigned-access pulse, aligned with the response slot |
| rf_idx | output | AW-6 | Register slot number |
| rf_hit | output | 1 | Current address decodes to a mapped slot |
| rf_wr | output | 1 | 64-bit commit strobe |
| rf_rd | output | 1 | 64-bit read strobe |
| rf_wdata | output | 64 | 64-bit commit value |
| rf_rdata | input | 64 | 64-bit value of the slot at `rf_idx` |

## Verification
Two uses of the latch can fall on adjacent edges with no idle gap. The latch is loaded at one edge by a low-half write or a low-half read, and the very next request consumes it: a high-half write folds it into the commit value, or a high-half read returns it. Back-to-back request streams provoke this. The scoreboard keeps its own copy of the latch and of the register contents, so any stale or skipped latch update shows up either in the committed word or in the data a later read returns. The second coincidence is the response slot of an unmapped low-half read, where the error pulse and the all-ones data arrive together. The check there is that a high-half read issued next still sees the older latch value.

// File: rtl/hbsb_pkg.sv
package hbsb_pkg;
    localparam int HALF_W   = 32;
    localparam int FULL_W   = 64;
    localparam int SLOT_LSB = 6;   // 0x40-byte slot stride
    localparam int HALF_BIT = 2;   // selects latch half vs register half

    typedef struct packed {
        logic [HALF_W-1:0] latch;
        logic [HALF_W-1:0] rdata;
        logic              rvalid;
        logic              err;
    } bridge_state_t;
endpackage

// File: rtl/hbsb_decode.sv
module hbsb_decode
    import hbsb_pkg::*;
#(
    parameter int AW       = 16,
    parameter int NUM_REGS = 8,
    localparam int IW      = AW - SLOT_LSB
) (
    input  logic [AW-1:0] addr,
    output logic [IW-1:0] idx,
    output logic          hi_half,
    output logic          hit
);
    localparam logic [IW-1:0] LIMIT = IW'(NUM_REGS);

    always_comb begin
        idx     = addr[AW-1:SLOT_LSB];
        hi_half = addr[HALF_BIT];
        hit     = (addr[SLOT_LSB-1:3] == '0) && (addr[AW-1:SLOT_LSB] < LIMIT);
    end
endmodule

// File: rtl/hbsb_seq.sv
module hbsb_seq
    import hbsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic              hi_half,
    input  logic              hit,
    input  logic [HALF_W-1:0] wdata,
    input  logic [FULL_W-1:0] rf_rdata,
    output logic              rf_wr,
    output logic              rf_rd,
    output logic [FULL_W-1:0] rf_wdata,
    output logic [HALF_W-1:0] rdata,
    output logic              rvalid,
    output logic              err
);
    bridge_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.err    = 1'b0;
        rf_wr       = 1'b0;
        rf_rd       = 1'b0;
        rf_wdata    = {wdata, st_q.latch};
        if (req) begin
            if (we) begin
                if (!hi_half) begin
                    st_d.latch = wdata;
                end else if (hit) begin
                    rf_wr = 1'b1;
                end else begin
                    st_d.err = 1'b1;
                end
            end else begin
                st_d.rvalid = 1'b1;
                if (hi_half) begin
                    st_d.rdata = st_q.latch;
                end else if (hit) begin
                    rf_rd      = 1'b1;
                    st_d.rdata = rf_rdata[HALF_W-1:0];
                    st_d.latch = rf_rdata[FULL_W-1:HALF_W];
                end else begin
                    st_d.rdata = '1;
                    st_d.err   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata  = st_q.rdata;
    assign rvalid = st_q.rvalid;
    assign err    = st_q.err;

    // R3 / R7: commit only for a mapped high-half write
    a_r3_commit_mapped: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr |-> (req && we && hi_half && hit));
    // R4: register read strobe only for a mapped low-half read
    a_r4_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd |-> (req && !we && !hi_half && hit));
    // R2: low-half write yields no response and no error
    a_r2_quiet_park: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && !hi_half) |=> (!rvalid && !err));
    // R5: high-half read never errs and never moves the latch
    a_r5_latch_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && hi_half) |=> (rvalid && !err && rdata == $past(st_q.latch)));
    // R6: erroring read returns all ones
    a_r6_ones_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && err) |-> (rdata == '1));
    // R9: responses only follow a request
    a_r9_resp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid || err) |-> $past(req));
endmodule

// File: rtl/hbsb_bridge.sv
module hbsb_bridge
    import hbsb_pkg::*;
#(
    parameter int AW       = 16,
    parameter int NUM_REGS = 8,
    localparam int IW      = AW - SLOT_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_req,
    input  logic              hst_we,
    input  logic [AW-1:0]     hst_addr,
    input  logic [HALF_W-1:0] hst_wdata,
    output logic [HALF_W-1:0] hst_rdata,
    output logic              hst_rvalid,
    output logic              hst_err,
    output logic [IW-1:0]     rf_idx,
    output logic              rf_hit,
    output logic              rf_wr,
    output logic              rf_rd,
    output logic [FULL_W-1:0] rf_wdata,
    input  logic [FULL_W-1:0] rf_rdata
);
    logic hi_half;

    hbsb_decode #(.AW(AW), .NUM_REGS(NUM_REGS)) u_decode (
        .addr    (hst_addr),
        .idx     (rf_idx),
        .hi_half (hi_half),
        .hit     (rf_hit)
    );

    hbsb_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (hst_req),
        .we       (hst_we),
        .hi_half  (hi_half),
        .hit      (rf_hit),
        .wdata    (hst_wdata),
        .rf_rdata (rf_rdata),
        .rf_wr    (rf_wr),
        .rf_rd    (rf_rd),
        .rf_wdata (rf_wdata),
        .rdata    (hst_rdata),
        .rvalid   (hst_rvalid),
        .err      (hst_err)
    );

    // R1: no strobes or responses while in reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!hst_rvalid && !hst_err));
    // R8: strobes are never issued for an unmapped decode
    a_r8_strobe_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr || rf_rd) |-> rf_hit);
endmodule

// File: tb/hbsb_bridge_bench.sv
module hbsb_bridge_bench;
    localparam int AW = 16;
    localparam int NR = 8;
    localparam int IW = AW - 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hst_req = 1'b0, hst_we = 1'b0;
    logic [AW-1:0] hst_addr = '0;
    logic [31:0]   hst_wdata = '0;
    logic [31:0]   hst_rdata;
    logic          hst_rvalid, hst_err;
    logic [IW-1:0] rf_idx;
    logic          rf_hit, rf_wr, rf_rd;
    logic [63:0]   rf_wdata, rf_rdata;

    logic [63:0] mem [NR];
    logic [63:0] ref_mem [NR];
    logic [31:0] exp_latch;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    typedef struct packed { logic rv; logic er; logic chk_data; logic [31:0] d; } exp_t;
    exp_t  q_exp[$];
    string q_tag[$];

    always #5 clk = ~clk;

    hbsb_bridge #(.AW(AW), .NUM_REGS(NR)) u_hbsb_bridge (.*);

    assign rf_rdata = (int'(rf_idx) < NR) ? mem[rf_idx] : 64'h0;
    always @(posedge clk) if (rf_wr && int'(rf_idx) < NR) mem[rf_idx] <= rf_wdata;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit mapped(input logic [AW-1:0] a);
        return (a[5:3] == 3'b0) && (int'(a[AW-1:6]) < NR);
    endfunction

    // monitor: compares the response slot one cycle after each driven cycle
    initial begin
        forever begin
            @(posedge clk); #1;
            if (q_exp.size() > 0) begin
                exp_t e; string t;
                e = q_exp.pop_front(); t = q_tag.pop_front();
                chk(hst_rvalid == e.rv, {t, " rvalid"}, 64'(hst_rvalid), 64'(e.rv));
                chk(hst_err == e.er, {t, " err"}, 64'(hst_err), 64'(e.er));
                if (e.chk_data) chk(hst_rdata == e.d, {t, " rdata"}, 64'(hst_rdata), 64'(e.d));
            end
        end
    end

    task automatic access(input bit we, input logic [AW-1:0] a, input logic [31:0] wd, input string tag);
        exp_t e;
        bit hi, hit;
        int ix;
        @(negedge clk);
        hst_req = 1'b1; hst_we = we; hst_addr = a; hst_wdata = wd;
        #1;
        hi = a[2]; hit = mapped(a); ix = int'(a[AW-1:6]);
        e = '0;
        if (we) begin
            if (!hi) begin
                chk(rf_wr == 1'b0, {tag, " no commit on low write"}, 64'(rf_wr), 64'd0);
                exp_latch = wd;
            end else if (hit) begin
                chk(rf_wr == 1'b1, {tag, " commit strobe"}, 64'(rf_wr), 64'd1);
                chk(rf_wdata == {wd, exp_latch}, {tag, " commit value"}, rf_wdata, {wd, exp_latch});
                chk(int'(rf_idx) == ix, {tag, " commit slot"}, 64'(rf_idx), 64'(ix));
                ref_mem[ix] = {wd, exp_latch};
            end else begin
                chk(rf_wr == 1'b0, {tag, " no commit unmapped"}, 64'(rf_wr), 64'd0);
                e.er = 1'b1;
            end
        end else begin
            e.rv = 1'b1; e.chk_data = 1'b1;
            if (hi) e.d = exp_latch;
            else if (hit) begin
                chk(rf_rd == 1'b1, {tag, " read strobe"}, 64'(rf_rd), 64'd1);
                e.d = ref_mem[ix][31:0];
                exp_latch = ref_mem[ix][63:32];
            end else begin
                e.d = 32'hFFFF_FFFF; e.er = 1'b1;
            end
        end
        q_exp.push_back(e); q_tag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        hst_req = 1'b0; hst_we = 1'b0;
        q_exp.push_back('0); q_tag.push_back("R9 idle");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NR; i++) begin
            mem[i]     = {32'hA5A5_0000 + 32'(i), 32'h1234_0000 + 32'(i)};
            ref_mem[i] = mem[i];
        end
        exp_latch = 32'h0;
        repeat (3) @(posedge clk);
        #1;
        chk(!hst_rvalid && !hst_err, "R1 reset outputs", 64'({hst_rvalid, hst_err}), 64'd0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(!rf_wr && !rf_rd, "R1 reset strobes", 64'({rf_wr, rf_rd}), 64'd0);

        access(0, 16'h0004, '0, "R1 latch zero after reset");
        access(0, 16'h0000, '0, "R4 low read slot0");
        access(0, 16'h0004, '0, "R5 high read slot0");
        access(1, 16'h0040, 32'hDEAD_BEEF, "R2 park low");
        access(1, 16'h0044, 32'hCAFE_F00D, "R3 commit slot1");
        access(0, 16'h0040, '0, "R3 readback low slot1");
        access(0, 16'h0044, '0, "R3 readback high slot1");
        idle();
        access(0, 16'h0200, '0, "R6 unmapped read slot8");
        access(0, 16'h0204, '0, "R6 latch kept after unmapped");
        access(0, 16'h0008, '0, "R8 unmapped gap offset");
        access(0, 16'h0204, '0, "R5 high read unmapped offset");
        access(1, 16'h0000, 32'h0BAD_0BAD, "R2 park before bad commit");
        access(1, 16'h0204, 32'h7777_7777, "R7 unmapped high write");
        access(0, 16'h0200, '0, "R7 no change check slot8");
        access(1, 16'h0080, 32'h1111_2222, "R10 park low slot2");
        access(0, 16'h00C0, '0, "R10 intervening read slot3");
        access(1, 16'h0084, 32'h3333_4444, "R10 commit slot2");
        access(0, 16'h0080, '0, "R10 readback low slot2");
        access(0, 16'h0083, '0, "R8 addr bits 1:0 ignored");
        access(0, 16'h0087, '0, "R8 high read bits 1:0 ignored");
        access(1, 16'h01C0, 32'h5555_6666, "R2 park low slot7");
        access(1, 16'h01C4, 32'h7777_8888, "R3 commit last slot7");
        for (int i = 0; i < NR; i++) begin
            access(1, AW'(i * 64), 32'h9000_0000 + 32'(i), "R2 sweep park");
            access(1, AW'(i * 64 + 4), 32'h8000_0000 + 32'(i), "R3 sweep commit");
        end
        for (int i = 0; i < NR; i++) begin
            access(0, AW'(i * 64), '0, "R4 sweep low read");
            access(0, AW'(i * 64 + 4), '0, "R5 sweep high read");
        end
        idle();
        idle();
        @(posedge clk); #2;
        for (int i = 0; i < NR; i++)
            chk(mem[i] == ref_mem[i], "R3 final register contents", mem[i], ref_mem[i]);
        finish_run();
    end
endmodule